// File: doc/BRIEF.md
# Pulse-Delay Prefix Bit Counter

The block computes the inclusive prefix count of set bits across a row of N one-bit cells. No adder tree does this. A single pulse is launched at the leader cell (cell 0) and travels down the chain. Every clock cycle is one time slot, and the pulse moves one cell per slot. A cell whose bit is one holds the pulse back by exactly one extra slot.

All cells start a slot counter on the same start strobe. A cell's counter freezes in the slot where the pulse reaches it. The cell's count output is the frozen slot number minus its distance from the leader, minus one. The result is the number of set bits from the leader up to and including that cell.

A user places a vector on the bit inputs and pulses the start strobe for one cycle. The user then waits for the done flag and reads the N count fields. The run length depends on the data: it is N slots plus one slot for every set bit. A fresh strobe at any time abandons the current run and begins a new one.

Top module: `pulse_prefix_counter`

## Requirements
- R1: After reset, done_o is 0 and every count field reads 0 until a start strobe is taken.
- R2: The bit vector is captured on the clock edge that samples start_i high. Changes on bits_i after that edge have no effect on the run's results.
- R3: Once done_o is 1, count field i (bits [i*OW +: OW] of counts_o, OW = clog2(N+1)) equals the number of ones among captured bits 0..i. Bit i of bits_i belongs to cell i, and cell 0 is the leader.
- R4: The leader launches the pulse in slot 1 when its bit is 0 and in slot 2 when its bit is 1. Its count field therefore equals its own captured bit.
- R5: done_o first reads 1 after exactly N + (number of ones in the captured vector) rising edges following the start edge, and never later than 2N.
- R6: After done_o rises, done_o and all count fields stay constant until the next start strobe, whatever bits_i does.
- R7: A start strobe taken during a run or after it clears all counters. In the cycle after the strobe edge, done_o is 0 and every count field is 0. The new run then completes for the new vector as in R3 and R5.
- R8: A cell's count field reads 0 until the pulse has reached that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that captures bits_i and begins a run |
| bits_i | input | N | One bit per cell, bit 0 at the leader |
| done_o | output | 1 | High once the pulse has reached the last cell |
| counts_o | output | N*OW | Packed inclusive prefix counts, field i at [i*OW +: OW] |

## Verification
An 8-cell instance is driven with every one of the 256 bit vectors, so all-zero, all-one, lone-bit and alternating patterns are all covered. For each vector, the cycle on which done rises is compared with N plus the population count. This separates a correct delay of one slot per set bit from missing or doubled delays. Every count field is compared with a running sum, and the leader's field exposes the slot-1 versus slot-2 launch rule. A second sweep complements the inputs right after the strobe to show that only the captured bits count. A restart issued in the middle of a run shows that a new strobe clears the previous run.

// File: rtl/ppc_pkg.sv
`timescale 1ns/1ps
package ppc_pkg;

   // Width of a slot counter able to hold the latest arrival slot (2n).
   function automatic int slot_width(input int n);
      return $clog2(2 * n + 1);
   endfunction

   // Width of a prefix count able to hold n.
   function automatic int count_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // Largest number of cells the block accepts.
   localparam int MAX_CELLS = 1024;

endpackage

// File: rtl/ppc_launch.sv
`timescale 1ns/1ps
// Captures the operand on the start strobe and emits the leader's launch
// pulse in the first slot of the run.
module ppc_launch #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [N-1:0] bits_i,
   output logic [N-1:0] bits_q,
   output logic         launch_q,
   output logic         run_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q   <= '0;
         launch_q <= 1'b0;
         run_q    <= 1'b0;
      end else begin
         launch_q <= start_i;
         if (start_i) begin
            bits_q <= bits_i;
            run_q  <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ppc_cell.sv
`timescale 1ns/1ps
// One cell of the chain: optional one-slot delay, a slot counter that
// freezes on pulse arrival, and the prefix readout.
module ppc_cell #(
   parameter int IDX = 0,
   parameter int CW  = 5,
   parameter int OW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          run_i,
   input  logic          bit_i,
   input  logic          pulse_i,
   output logic          pulse_o,
   output logic          frozen_o,
   output logic [OW-1:0] count_o
);

   localparam logic [CW-1:0] OFFSET = CW'(IDX + 1);

   logic          dly_q;
   logic          fwd_q;
   logic          frozen_q;
   logic [CW-1:0] slot_q;
   logic          hit;

   // A set bit makes the pulse arrive one slot later.
   assign hit = bit_i ? dly_q : pulse_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_q    <= 1'b0;
         fwd_q    <= 1'b0;
         frozen_q <= 1'b0;
         slot_q   <= '0;
      end else if (clr_i) begin
         dly_q    <= 1'b0;
         fwd_q    <= 1'b0;
         frozen_q <= 1'b0;
         slot_q   <= '0;
      end else begin
         dly_q <= pulse_i;
         fwd_q <= hit;
         if (run_i && !frozen_q) begin
            slot_q <= slot_q + 1'b1;
            if (hit) begin
               frozen_q <= 1'b1;
            end
         end
      end
   end

   assign pulse_o  = fwd_q;
   assign frozen_o = frozen_q;
   assign count_o  = frozen_q ? OW'(slot_q - OFFSET) : '0;

endmodule

// File: rtl/pulse_prefix_counter.sv
`timescale 1ns/1ps
module pulse_prefix_counter #(
   parameter int N  = 8,
   parameter int CW = ppc_pkg::slot_width(N),
   parameter int OW = ppc_pkg::count_width(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [N-1:0]    bits_i,
   output logic            done_o,
   output logic [N*OW-1:0] counts_o
);

   // Elaboration-time parameter checks.
   if (N < 1 || N > ppc_pkg::MAX_CELLS) begin : g_bad_n
      $error("pulse_prefix_counter: N out of range");
   end
   if (CW < ppc_pkg::slot_width(N)) begin : g_bad_cw
      $error("pulse_prefix_counter: CW too narrow for 2N slots");
   end
   if (OW < ppc_pkg::count_width(N)) begin : g_bad_ow
      $error("pulse_prefix_counter: OW too narrow for N");
   end

   logic [N-1:0] bits_q;
   logic         launch_q;
   logic         run_q;
   logic [N:0]   chain_w;
   logic [N-1:0] pulse_w;
   logic [N-1:0] frozen_w;

   ppc_launch #(.N(N)) launch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .bits_i   (bits_i),
      .bits_q   (bits_q),
      .launch_q (launch_q),
      .run_q    (run_q)
   );

   assign chain_w[0] = launch_q;

   for (genvar c = 0; c < N; c++) begin : g_cell
      ppc_cell #(.IDX(c), .CW(CW), .OW(OW)) cell_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_i    (start_i),
         .run_i    (run_q),
         .bit_i    (bits_q[c]),
         .pulse_i  (chain_w[c]),
         .pulse_o  (chain_w[c+1]),
         .frozen_o (frozen_w[c]),
         .count_o  (counts_o[c*OW +: OW])
      );
      assign pulse_w[c] = chain_w[c+1];
   end

   assign done_o = frozen_w[N-1];

endmodule

// File: rtl/ppc_checker.sv
`timescale 1ns/1ps
module ppc_checker #(
   parameter int N  = 8,
   parameter int OW = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic            done_o,
   input logic [N*OW-1:0] counts_o,
   input logic [N-1:0]    frozen_w,
   input logic [N-1:0]    pulse_w
);

   localparam int LIMIT = 2 * N;
   localparam int WW    = $clog2(LIMIT + 2) + 1;

   logic [WW-1:0] wait_q;
   logic          seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q <= '0;
         seen_q <= 1'b0;
      end else if (start_i) begin
         wait_q <= '0;
         seen_q <= 1'b1;
      end else if (wait_q < WW'(LIMIT + 1)) begin
         wait_q <= wait_q + 1'b1;
      end
   end

   // R5
   done_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && wait_q >= WW'(LIMIT)) |-> done_o);

   // R5
   done_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q < WW'(N)) |-> !done_o);

   // R1
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> (!done_o && counts_o == '0));

   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(counts_o)));

   // R7
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (frozen_w == '0 && !done_o && counts_o == '0));

   // R3
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pulse_w));

   // R8
   done_all_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (&frozen_w));

   // R4
   leader_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (counts_o[OW-1:0] <= OW'(1)));

   for (genvar c = 1; c < N; c++) begin : g_step
      // R3
      prefix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done_o |-> ((counts_o[c*OW +: OW] - counts_o[(c-1)*OW +: OW]) <= OW'(1)));
   end

endmodule

bind pulse_prefix_counter ppc_checker #(.N(N), .OW(OW)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .done_o   (done_o),
   .counts_o (counts_o),
   .frozen_w (frozen_w),
   .pulse_w  (pulse_w)
);

// File: tb/pulse_prefix_counter_tb_top.sv
`timescale 1ns/1ps
module pulse_prefix_counter_tb_top;

   localparam int N  = 8;
   localparam int OW = $clog2(N + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [N-1:0]    bits_i = '0;
   logic            done_o;
   logic [N*OW-1:0] counts_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pulse_prefix_counter #(.N(N)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .bits_i   (bits_i),
      .done_o   (done_o),
      .counts_o (counts_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int field(input int c);
      return int'(counts_o[c*OW +: OW]);
   endfunction

   // Strobe start with vector v; check the cleared state one cycle later.
   task automatic strobe(input logic [N-1:0] v, input bit flip);
      @(negedge clk);
      bits_i  = v;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (flip) bits_i = ~v;
      chk(done_o == 1'b0, "R7 done after strobe", int'(done_o), 0);
      chk(counts_o == '0, "R8 counts after strobe", int'(counts_o), 0);
   endtask

   // Count edges after the strobe edge until done is seen; then check results.
   task automatic finish_run(input logic [N-1:0] v, input string tag);
      int k = 0;
      int pc = 0;
      int sum = 0;
      for (int c = 0; c < N; c++) pc += int'(v[c]);
      while (k < 4 * N) begin
         @(posedge clk);
         k++;
         @(negedge clk);
         if (done_o) break;
      end
      chk(k == N + pc, {"R5 latency ", tag}, k, N + pc);
      chk(field(0) == int'(v[0]), {"R4 leader ", tag}, field(0), int'(v[0]));
      for (int c = 0; c < N; c++) begin
         sum += int'(v[c]);
         chk(field(c) == sum, {"R3 prefix ", tag}, field(c), sum);
      end
   endtask

   initial begin
      logic [N*OW-1:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      bits_i = '1;
      @(negedge clk);
      // R1
      chk(done_o == 1'b0, "R1 done at reset", int'(done_o), 0);
      chk(counts_o == '0, "R1 counts at reset", int'(counts_o), 0);

      // R3 R4 R5: exhaustive sweep
      for (int v = 0; v < (1 << N); v++) begin
         strobe(N'(v), 1'b0);
         finish_run(N'(v), "sweep");
      end

      // R2: inputs complemented right after capture
      for (int v = 0; v < (1 << N); v += 7) begin
         strobe(N'(v), 1'b1);
         finish_run(N'(v), "R2 capture");
      end

      // R6: results hold while inputs move
      strobe(8'b1011_0010, 1'b0);
      finish_run(8'b1011_0010, "hold setup");
      snap = counts_o;
      for (int i = 0; i < 5; i++) begin
         bits_i = N'(i * 37);
         @(negedge clk);
         chk(done_o == 1'b1, "R6 done holds", int'(done_o), 1);
         chk(counts_o == snap, "R6 counts hold", int'(counts_o), int'(snap));
      end

      // R7: restart in mid-run
      strobe('1, 1'b0);
      repeat (4) @(negedge clk);
      strobe(8'b0100_0001, 1'b0);
      finish_run(8'b0100_0001, "R7 restart");
      strobe('0, 1'b0);
      repeat (N - 2) @(negedge clk);
      strobe(8'b1111_0000, 1'b0);
      finish_run(8'b1111_0000, "R7 restart late");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule